// File: doc/BRIEF.md
# Ethernet VLAN Tag Receive Matcher

This block watches the receive byte stream of an Ethernet MAC and decides, frame by frame, whether the frame carries an IEEE 802.1Q tag equal to a programmed value. Header bytes arrive one per accepted beat, and the first byte of a frame is flagged by `s_sof`. The block checks the Length/Type pair for the tag protocol identifier 0x8100. It then checks the two tag control bytes that follow against `cfg_tag`. The result appears on `st_vlan` as soon as byte 16 has been taken.

At the last byte of the frame, the block raises a one-cycle `st_done`. Alongside it, `st_oversize` reports whether the frame was longer than its legal maximum. That maximum is 1518 bytes for an ordinary frame and 1522 bytes for a frame whose tag matched.

The input is a valid/ready stream. The block never back-pressures: `s_ready` is high whenever reset is released, and the sender may drop `s_valid` between any two bytes. The configuration pins are plain levels. They must be held stable while a frame is passing.

Top module: `vlan_rx_match`

## Requirements
- R1: Out of reset `s_ready` is 1, so every beat with `s_valid` high is accepted at that clock edge.
- R2: A match needs frame byte 13 equal to 0x81 and byte 14 equal to 0x00, where byte 1 is the beat carrying `s_sof`.
- R3: With `cfg_vid_only` = 0, byte 15 must equal `cfg_tag[15:8]` and byte 16 must equal `cfg_tag[7:0]`.
- R4: With `cfg_vid_only` = 1, only the 12-bit VLAN ID is compared. That is `cfg_tag[11:0]` against the low nibble of byte 15 together with all of byte 16, and the high nibble of byte 15 is ignored.
- R5: When the compared part of `cfg_tag` is all zeros, no frame matches.
- R6: `st_vlan` goes to 0 at the edge that accepts a start-of-frame beat. It goes to 1 at the edge that accepts byte 16 of a matching frame, and holds otherwise. A frame shorter than 16 bytes never sets it.
- R7: `st_done` is high for exactly the cycle after the end-of-frame beat is accepted. In that cycle `st_oversize` is 1 if the frame length exceeds 1522 bytes for a matched frame, or 1518 bytes otherwise. `st_oversize` holds its value until the next `st_done`.
- R8: A beat accepted outside a frame (after an end-of-frame beat and before the next start-of-frame beat) is ignored. It produces no `st_done` and does not change `st_vlan`.
- R9: During reset `st_vlan`, `st_done` and `st_oversize` are 0.
- R10: The byte counter saturates at its maximum, and a frame longer than that still reports oversize.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Receive byte present |
| s_ready | output | 1 | Byte accepted when high together with `s_valid` |
| s_data | input | 8 | Receive byte |
| s_sof | input | 1 | Beat is the first byte of a frame |
| s_eof | input | 1 | Beat is the last byte of a frame |
| cfg_tag | input | 16 | Programmed tag control value |
| cfg_vid_only | input | 1 | 1: compare the 12-bit VLAN ID only; 0: compare all 16 bits |
| st_vlan | output | 1 | Current frame matched the programmed tag |
| st_done | output | 1 | One-cycle end-of-frame strobe |
| st_oversize | output | 1 | Length over the applicable limit; valid with `st_done` |

## Verification
The assertions check these behaviours on every cycle:
- `st_done` follows an accepted end-of-frame beat by one cycle and never appears otherwise.
- `st_vlan` clears after a start-of-frame beat and holds on idle cycles.
- `st_vlan` never rises while the masked tag is zero.
- `st_oversize` moves only together with `st_done`.
- All outputs are zero in reset.

The byte comparisons cannot be shown by a property and are left to the bench's scenarios. These are the protocol identifier and tag bytes, the ID-only mask, frames too short to match, the exact 1518/1522 length boundaries, and counter saturation.

// File: rtl/vlan_rx_pkg.sv
package vlan_rx_pkg;
  // header byte positions, counting the start-of-frame beat as 1
  localparam int POS_TPID_HI = 13;
  localparam int POS_TPID_LO = 14;
  localparam int POS_TCI_HI  = 15;
  localparam int POS_TCI_LO  = 16;

  localparam logic [7:0] TPID_HI = 8'h81;
  localparam logic [7:0] TPID_LO = 8'h00;

  localparam logic [15:0] MASK_FULL = 16'hFFFF;
  localparam logic [15:0] MASK_VID  = 16'h0FFF;
endpackage

// File: rtl/vlan_byte_cnt.sv
module vlan_byte_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  output logic             take,
  output logic             in_frame,
  output logic [CNT_W-1:0] cur_idx
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // a beat counts only when it opens a frame or lies inside one
  assign take = beat && (sof || in_frame);

  always_comb begin
    if (sof)                 cur_idx = ONE;
    else if (cnt_q == CNT_MAX) cur_idx = CNT_MAX;
    else                     cur_idx = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      in_frame <= 1'b0;
    end else if (take) begin
      cnt_q    <= cur_idx;
      in_frame <= !eof;
    end
  end
endmodule

// File: rtl/vlan_hdr_cmp.sv
module vlan_hdr_cmp #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CNT_W-1:0] cur_idx,
  input  logic [7:0]       data,
  input  logic [15:0]      cfg_tag,
  input  logic             cfg_vid_only,
  output logic             hit
);
  import vlan_rx_pkg::*;

  localparam logic [CNT_W-1:0] I_T1 = CNT_W'(POS_TPID_HI);
  localparam logic [CNT_W-1:0] I_T2 = CNT_W'(POS_TPID_LO);
  localparam logic [CNT_W-1:0] I_V1 = CNT_W'(POS_TCI_HI);
  localparam logic [CNT_W-1:0] I_V2 = CNT_W'(POS_TCI_LO);

  logic [15:0] mask, want;
  logic [7:0]  exp_b, msk_b;
  logic        byte_ok, tag_nz, run_ok_q;

  assign mask   = cfg_vid_only ? MASK_VID : MASK_FULL;
  assign want   = cfg_tag & mask;
  assign tag_nz = |want;

  always_comb begin
    exp_b = 8'h00;
    msk_b = 8'hFF;
    if (cur_idx == I_T1) begin
      exp_b = TPID_HI;
    end else if (cur_idx == I_T2) begin
      exp_b = TPID_LO;
    end else if (cur_idx == I_V1) begin
      exp_b = want[15:8];
      msk_b = mask[15:8];
    end else if (cur_idx == I_V2) begin
      exp_b = want[7:0];
      msk_b = mask[7:0];
    end
  end

  assign byte_ok = (data & msk_b) == exp_b;

  // running result over bytes 13..15; byte 16 is judged combinationally
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_ok_q <= 1'b0;
    end else if (take) begin
      if (cur_idx == I_T1)
        run_ok_q <= byte_ok;
      else if (cur_idx == I_T2 || cur_idx == I_V1)
        run_ok_q <= run_ok_q && byte_ok;
    end
  end

  assign hit = take && (cur_idx == I_V2) && run_ok_q && byte_ok && tag_nz;
endmodule

// File: rtl/vlan_len_chk.sv
module vlan_len_chk #(
  parameter int CNT_W     = 12,
  parameter int BASE_MAX  = 1518,
  parameter int TAG_EXTRA = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sof,
  input  logic             eof,
  input  logic [CNT_W-1:0] cur_idx,
  input  logic             hit,
  output logic             st_vlan,
  output logic             st_done,
  output logic             st_oversize
);
  localparam logic [CNT_W-1:0] LIM_PLAIN  = CNT_W'(BASE_MAX);
  localparam logic [CNT_W-1:0] LIM_TAGGED = CNT_W'(BASE_MAX + TAG_EXTRA);

  logic vlan_now, over;

  assign vlan_now = hit || (st_vlan && !sof);
  assign over     = cur_idx > (vlan_now ? LIM_TAGGED : LIM_PLAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_vlan     <= 1'b0;
      st_done     <= 1'b0;
      st_oversize <= 1'b0;
    end else begin
      st_done <= take && eof;
      if (take && sof)
        st_vlan <= 1'b0;
      else if (hit)
        st_vlan <= 1'b1;
      if (take && eof)
        st_oversize <= over;
    end
  end
endmodule

// File: rtl/vlan_rx_match.sv
module vlan_rx_match #(
  parameter int CNT_W     = 12,
  parameter int BASE_MAX  = 1518,
  parameter int TAG_EXTRA = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_sof,
  input  logic        s_eof,
  input  logic [15:0] cfg_tag,
  input  logic        cfg_vid_only,
  output logic        st_vlan,
  output logic        st_done,
  output logic        st_oversize
);
  logic             beat, take, in_frame, hit;
  logic [CNT_W-1:0] cur_idx;

  assign s_ready = rst_n;
  assign beat    = s_valid && s_ready;

  vlan_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(s_sof), .eof(s_eof),
    .take(take), .in_frame(in_frame), .cur_idx(cur_idx)
  );

  vlan_hdr_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .take(take), .cur_idx(cur_idx), .data(s_data),
    .cfg_tag(cfg_tag), .cfg_vid_only(cfg_vid_only), .hit(hit)
  );

  vlan_len_chk #(.CNT_W(CNT_W), .BASE_MAX(BASE_MAX), .TAG_EXTRA(TAG_EXTRA)) u_len (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(s_sof), .eof(s_eof),
    .cur_idx(cur_idx), .hit(hit), .st_vlan(st_vlan), .st_done(st_done),
    .st_oversize(st_oversize)
  );
endmodule

// File: rtl/vlan_rx_match_chk.sv
module vlan_rx_match_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        s_ready,
  input logic        s_sof,
  input logic        s_eof,
  input logic        in_frame,
  input logic [15:0] cfg_tag,
  input logic        cfg_vid_only,
  input logic        st_vlan,
  input logic        st_done,
  input logic        st_oversize
);
  logic        live, acc, acc_end;
  logic [15:0] masked;

  assign acc     = s_valid && s_ready;
  assign acc_end = acc && s_eof && (s_sof || in_frame);
  assign masked  = cfg_tag & (cfg_vid_only ? 16'h0FFF : 16'hFFFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // R7
  done_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (st_done == $past(acc_end)));

  // R6
  sof_clears_vlan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && s_sof) |=> !st_vlan);

  // R6
  vlan_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !acc) |=> $stable(st_vlan));

  // R5
  zero_tag_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $rose(st_vlan)) |-> ($past(masked) != 16'h0000));

  // R7
  oversize_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !st_done) |-> $stable(st_oversize));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!st_done && !st_vlan && !st_oversize));
endmodule

bind vlan_rx_match vlan_rx_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_sof(s_sof), .s_eof(s_eof), .in_frame(in_frame), .cfg_tag(cfg_tag),
  .cfg_vid_only(cfg_vid_only), .st_vlan(st_vlan), .st_done(st_done),
  .st_oversize(st_oversize)
);

// File: tb/vlan_rx_match_bench.sv
module vlan_rx_match_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic [15:0] cfg_tag = 16'h0000;
  logic        cfg_vid_only = 1'b0;
  logic        s_ready, st_vlan, st_done, st_oversize;

  typedef struct { logic vlan; logic ov; string name; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  vlan_rx_match u_vlan_rx_match (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .cfg_tag(cfg_tag),
    .cfg_vid_only(cfg_vid_only), .st_vlan(st_vlan), .st_done(st_done),
    .st_oversize(st_oversize)
  );

  function automatic void chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  // monitor: pop the expected status for every end-of-frame strobe
  always @(negedge clk) begin
    if (rst_n && st_done) begin
      if (q.size() == 0) begin
        chk(0, "R8/R7 strobe with no frame pending", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(st_vlan == e.vlan, {"R6 vlan ", e.name}, int'(st_vlan), int'(e.vlan));
        chk(st_oversize == e.ov, {"R7 oversize ", e.name}, int'(st_oversize), int'(e.ov));
      end
    end
  end

  task automatic send_frame(int len, logic [7:0] t1, logic [7:0] t2,
                            logic [7:0] v1, logic [7:0] v2,
                            logic ev, string name);
    exp_t e;
    int lim;
    lim = ev ? 1522 : 1518;
    e.vlan = ev; e.ov = (len > lim); e.name = name;
    q.push_back(e);
    for (int i = 1; i <= len; i++) begin
      if (i % 7 == 3) begin
        s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
        @(negedge clk);
      end
      s_valid = 1'b1;
      s_sof   = (i == 1);
      s_eof   = (i == len);
      case (i)
        13: s_data = t1;
        14: s_data = t2;
        15: s_data = v1;
        16: s_data = v2;
        default: s_data = 8'(i);
      endcase
      @(negedge clk);
      if (i == 1 && len > 1)
        chk(st_vlan == 1'b0, {"R6 cleared after start ", name}, int'(st_vlan), 0);
    end
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(st_vlan == 0 && st_done == 0 && st_oversize == 0, "R9 reset outputs",
        int'({st_vlan, st_done, st_oversize}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R1 ready after reset", int'(s_ready), 1);

    cfg_tag = 16'h3456; cfg_vid_only = 1'b0;
    send_frame(64, 8'h08, 8'h00, 8'h34, 8'h56, 0, "R2 plain type");
    send_frame(64, 8'h81, 8'h00, 8'h34, 8'h56, 1, "R3 full match");
    send_frame(64, 8'h81, 8'h00, 8'h34, 8'h57, 0, "R3 low byte differs");
    send_frame(64, 8'h81, 8'h01, 8'h34, 8'h56, 0, "R2 wrong identifier");
    send_frame(64, 8'h81, 8'h00, 8'hB4, 8'h56, 0, "R3 high nibble differs");

    cfg_tag = 16'h5123; cfg_vid_only = 1'b1;
    send_frame(64, 8'h81, 8'h00, 8'hA1, 8'h23, 1, "R4 id only match");
    send_frame(64, 8'h81, 8'h00, 8'hA1, 8'h24, 0, "R4 id differs");
    cfg_vid_only = 1'b0;
    send_frame(64, 8'h81, 8'h00, 8'hA1, 8'h23, 0, "R4 full compare sees nibble");

    cfg_tag = 16'h0000;
    send_frame(64, 8'h81, 8'h00, 8'h00, 8'h00, 0, "R5 zero tag");
    cfg_tag = 16'hF000; cfg_vid_only = 1'b1;
    send_frame(64, 8'h81, 8'h00, 8'hF0, 8'h00, 0, "R5 zero id");
    cfg_vid_only = 1'b0;
    send_frame(64, 8'h81, 8'h00, 8'hF0, 8'h00, 1, "R5 nonzero full");

    send_frame(15, 8'h81, 8'h00, 8'hF0, 8'h00, 0, "R6 fifteen bytes");
    send_frame(16, 8'h81, 8'h00, 8'hF0, 8'h00, 1, "R6 sixteen bytes");
    send_frame(1,  8'h81, 8'h00, 8'hF0, 8'h00, 0, "R7 single byte");

    send_frame(1518, 8'h08, 8'h00, 8'hF0, 8'h00, 0, "R7 plain at limit");
    send_frame(1519, 8'h08, 8'h00, 8'hF0, 8'h00, 0, "R7 plain over");
    send_frame(1522, 8'h81, 8'h00, 8'hF0, 8'h00, 1, "R7 tagged at limit");
    send_frame(1523, 8'h81, 8'h00, 8'hF0, 8'h00, 1, "R7 tagged over");
    send_frame(1520, 8'h81, 8'h00, 8'hF0, 8'h01, 0, "R7 unmatched tag uses plain limit");

    send_frame(20, 8'h81, 8'h00, 8'hF0, 8'h00, 1, "R8 before stray");
    for (int k = 0; k < 3; k++) begin
      s_valid = 1'b1; s_sof = 1'b0; s_eof = (k == 1); s_data = 8'h81;
      @(negedge clk);
    end
    s_valid = 1'b0; s_eof = 1'b0;
    repeat (3) @(negedge clk);
    chk(st_vlan == 1'b1, "R8 stray beats leave status", int'(st_vlan), 1);

    send_frame(4100, 8'h81, 8'h00, 8'hF0, 8'h00, 1, "R10 saturated length");
    send_frame(64, 8'h08, 8'h00, 8'hF0, 8'h00, 0, "R10 after saturation");

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R7 every frame reported", q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule